// File: doc/BRIEF.md
# Sprite XOR Blitter with Collision Flag

This block draws a sprite eight pixels wide and up to fifteen rows tall into a 64 by 32 monochrome framebuffer that lives in ordinary byte-addressed memory. The framebuffer holds one bit per pixel and eight bytes per row, stored row after row from a base address given with each command. Within a byte the most significant bit is the leftmost pixel. A caller supplies the start column and row, the row count, the address of the sprite bytes and the framebuffer base, then pulses `start`. The block then works through the rows on a single-port memory bus that makes one access per cycle.

For each row the block fetches the sprite byte and moves it right to the pixel column. It then XORs it into the one or two screen bytes it covers, using a read followed by a write. Start coordinates wrap around the screen, but pixels that would fall past the right edge or below the bottom are dropped. A collision flag reports whether any lit sprite pixel landed on a pixel that was already lit. An optional blank-wait request tells the surrounding processor to stall until its next timer tick.

Top module: `sprite_xor_blitter`

## Requirements
- R1: After reset, `busy`, `done`, `collision`, `blank_wait_req`, `mem_rd` and `mem_wr` are all low.
- R2: The start column is taken as `pos_x` mod 64 and the start row as `pos_y` mod 32. Both are captured when `start` is accepted.
- R3: Sprite row r (0 to rows-1) is read from `src_addr + r`. It is XORed into the screen byte at `fb_base + 8*(row + r) + col/8`, using the sprite byte shifted right by col mod 8. Bit 7 of a screen byte is its leftmost pixel.
- R4: When col mod 8 is not 0 and col/8 is less than 7, the bits shifted out (sprite << (8 - col mod 8), low 8 bits) are XORed into the next screen byte. Otherwise that next byte is neither read nor written, so nothing wraps horizontally.
- R5: A row whose screen row (start row + r) is 32 or more is not drawn, and the draw ends at the first such row.
- R6: `collision` is cleared when `start` is accepted. It is set when any sprite bit is XORed onto a screen bit that is already 1, and it holds its value until the next accepted `start`.
- R7: With `rows` = 0, `done` is high in the first cycle after `start` is accepted. `collision` reads 0 and no memory access takes place.
- R8: `done` is a one-cycle pulse. From the cycle that accepts `start`, it arrives after 3 cycles for each drawn row that touches one byte, plus 5 cycles for each drawn row that touches two bytes, plus 1. `busy` is high from the cycle after acceptance through the `done` cycle, and `start` is ignored while `busy` is high.
- R9: At most one of `mem_rd` or `mem_wr` is high in any cycle, and neither is high while idle. Read data is expected on `mem_rdata` in the cycle after `mem_rd`.
- R10: If `wait_en` is high when `start` is accepted, `blank_wait_req` goes high in the next cycle and stays high until a cycle with `vblank_tick` high, after which it goes low. If `wait_en` is low, `blank_wait_req` is not changed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a draw when idle |
| pos_x | input | 8 | Start column before wrapping |
| pos_y | input | 8 | Start row before wrapping |
| rows | input | 4 | Number of sprite rows, 0 to 15 |
| src_addr | input | 16 | Address of the first sprite byte |
| fb_base | input | 16 | Framebuffer base address |
| wait_en | input | 1 | Request a blank wait for this draw |
| vblank_tick | input | 1 | Timer tick that releases the blank wait |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| collision | output | 1 | Pixel erased during the last draw |
| blank_wait_req | output | 1 | Stall request until the next tick |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, one cycle after the read |

## Verification
Wrong sequencer state shows up within one draw. A skipped or extra row, or a wrong spill decision, changes the cycle count to `done`. It also leaves a framebuffer byte that differs from the model, and the bench compares every framebuffer byte as soon as `done` rises. A wrongly held or dropped collision bit is visible at `done`. Drawing the same sprite twice in a row forces the flag to 1 and restores the screen, so a missing XOR or a missing flag shows up two draws later at the latest. A sticky blank-wait request fails the check in the cycle after the tick.

// File: rtl/blit_pkg.sv
// Shared types for the sprite XOR blitter.
// Assumes nothing beyond IEEE 1800-2017 enums.
package blit_pkg;

    // Sequencer states: one memory access per busy state except the final one
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_FETCH = 3'd1,   // read sprite byte
        ST_RD_A  = 3'd2,   // capture sprite, read first screen byte
        ST_WR_A  = 3'd3,   // write first screen byte
        ST_RD_B  = 3'd4,   // read spill screen byte
        ST_WR_B  = 3'd5,   // write spill screen byte
        ST_FIN   = 3'd6    // done pulse
    } blit_state_e;

endpackage

// File: rtl/blit_shifter.sv
// Aligns one sprite byte to a pixel column.
// Produces the part for the covered byte and the part that spills into the
// next byte, plus a flag that says whether the spill byte must be touched.
// Assumes 8-pixel bytes with the leftmost pixel in bit 7.
module blit_shifter (
    input  logic [7:0] spr_byte,
    input  logic [2:0] bit_off,
    input  logic       last_col,
    output logic [7:0] part_a,
    output logic [7:0] part_b,
    output logic       spill
);
    logic [15:0] wide;

    // Shift the sprite across a 16-bit window and split it into two bytes
    always_comb begin
        wide   = {spr_byte, 8'h00} >> bit_off;
        part_a = wide[15:8];
        part_b = wide[7:0];
        spill  = (bit_off != 3'd0) && !last_col;
    end
endmodule

// File: rtl/blit_addr_gen.sv
// Forms the sprite source address and the two screen byte addresses of the
// current row. Assumes the row index stays on screen when it is used and
// that the spill byte is never past the row's last byte.
module blit_addr_gen #(
    parameter int ADDR_W = 16,
    parameter int BPR    = 8,
    parameter int YW     = 5,
    parameter int CW     = 3,
    parameter int RW     = 4
) (
    input  logic [ADDR_W-1:0] src_base,
    input  logic [ADDR_W-1:0] fb_base_q,
    input  logic [YW-1:0]     scr_row,
    input  logic [CW-1:0]     scr_col,
    input  logic [RW-1:0]     row_idx,
    output logic [ADDR_W-1:0] spr_addr,
    output logic [ADDR_W-1:0] addr_a,
    output logic [ADDR_W-1:0] addr_b
);
    // Combine bases with the row and column offsets
    always_comb begin
        spr_addr = src_base + ADDR_W'(row_idx);
        addr_a   = fb_base_q + ADDR_W'(scr_row) * ADDR_W'(BPR) + ADDR_W'(scr_col);
        addr_b   = addr_a + ADDR_W'(1);
    end
endmodule

// File: rtl/blit_wait_flag.sv
// Holds the blank-wait request: set by an accepted draw that asks for it,
// cleared by the timer tick. A set in the same cycle as a tick wins.
module blit_wait_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic tick,
    output logic req
);
    // Set/clear register with set priority
    always_ff @(posedge clk) begin
        if (!rst_n)       req <= 1'b0;
        else if (set_req) req <= 1'b1;
        else if (tick)    req <= 1'b0;
    end
endmodule

// File: rtl/sprite_xor_blitter.sv
// Sprite XOR blitter: draws an 8-pixel-wide sprite of up to 2**ROWS_W-1 rows
// into a 1 bpp framebuffer in byte memory through a one-access-per-cycle port.
// Assumes SCR_W and SCR_H are powers of two with SCR_W a multiple of 8, and
// a memory whose read data arrives the cycle after the read strobe.
module sprite_xor_blitter #(
    parameter int ADDR_W = 16,
    parameter int REG_W  = 8,
    parameter int ROWS_W = 4,
    parameter int SCR_W  = 64,
    parameter int SCR_H  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [REG_W-1:0]  pos_x,
    input  logic [REG_W-1:0]  pos_y,
    input  logic [ROWS_W-1:0] rows,
    input  logic [ADDR_W-1:0] src_addr,
    input  logic [ADDR_W-1:0] fb_base,
    input  logic              wait_en,
    input  logic              vblank_tick,
    output logic              busy,
    output logic              done,
    output logic              collision,
    output logic              blank_wait_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    import blit_pkg::*;

    localparam int BPR      = SCR_W / 8;
    localparam int XW       = $clog2(SCR_W);
    localparam int YW       = $clog2(SCR_H);
    localparam int CW       = (BPR > 1) ? $clog2(BPR) : 1;
    localparam int SUM_W    = ((YW > ROWS_W) ? YW : ROWS_W) + 1;
    localparam int FB_BYTES = BPR * SCR_H;

    blit_state_e       state;
    logic [XW-1:0]     x_r;
    logic [YW-1:0]     y_r;
    logic [ROWS_W-1:0] n_r;
    logic [ROWS_W-1:0] row_idx;
    logic [ADDR_W-1:0] src_r;
    logic [ADDR_W-1:0] base_r;
    logic [7:0]        spr_r;
    logic              coll_r;

    logic [SUM_W-1:0]  cur_row, next_row;
    logic [ROWS_W:0]   next_idx;
    logic              last_row;
    logic [CW-1:0]     col_byte;
    logic [7:0]        part_a, part_b;
    logic              spill;
    logic [ADDR_W-1:0] spr_addr, addr_a, addr_b;
    logic              accept;

    // Row bookkeeping: current screen row, next row, and end-of-draw test
    always_comb begin
        cur_row  = SUM_W'(y_r) + SUM_W'(row_idx);
        next_row = cur_row + SUM_W'(1);
        next_idx = {1'b0, row_idx} + 1'b1;
        last_row = (next_idx == {1'b0, n_r}) || (next_row >= SUM_W'(SCR_H));
        col_byte = CW'(x_r >> 3);
        accept   = (state == ST_IDLE) && start;
    end

    blit_shifter shift_i (
        .spr_byte (spr_r),
        .bit_off  (x_r[2:0]),
        .last_col (col_byte == CW'(BPR - 1)),
        .part_a   (part_a),
        .part_b   (part_b),
        .spill    (spill)
    );

    blit_addr_gen #(
        .ADDR_W (ADDR_W),
        .BPR    (BPR),
        .YW     (YW),
        .CW     (CW),
        .RW     (ROWS_W)
    ) addr_i (
        .src_base  (src_r),
        .fb_base_q (base_r),
        .scr_row   (cur_row[YW-1:0]),
        .scr_col   (col_byte),
        .row_idx   (row_idx),
        .spr_addr  (spr_addr),
        .addr_a    (addr_a),
        .addr_b    (addr_b)
    );

    blit_wait_flag wait_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_req (accept && wait_en),
        .tick    (vblank_tick),
        .req     (blank_wait_req)
    );

    // Sequencer: capture the command, then walk rows through read-modify-write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            x_r     <= '0;
            y_r     <= '0;
            n_r     <= '0;
            row_idx <= '0;
            src_r   <= '0;
            base_r  <= '0;
            spr_r   <= '0;
            coll_r  <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    x_r     <= pos_x[XW-1:0];
                    y_r     <= pos_y[YW-1:0];
                    n_r     <= rows;
                    src_r   <= src_addr;
                    base_r  <= fb_base;
                    row_idx <= '0;
                    coll_r  <= 1'b0;
                    state   <= (rows == '0) ? ST_FIN : ST_FETCH;
                end
                ST_FETCH: state <= ST_RD_A;
                ST_RD_A: begin
                    spr_r <= mem_rdata;
                    state <= ST_WR_A;
                end
                ST_WR_A: begin
                    if ((mem_rdata & part_a) != 8'h00) coll_r <= 1'b1;
                    if (spill) begin
                        state <= ST_RD_B;
                    end else begin
                        row_idx <= next_idx[ROWS_W-1:0];
                        state   <= last_row ? ST_FIN : ST_FETCH;
                    end
                end
                ST_RD_B: state <= ST_WR_B;
                ST_WR_B: begin
                    if ((mem_rdata & part_b) != 8'h00) coll_r <= 1'b1;
                    row_idx <= next_idx[ROWS_W-1:0];
                    state   <= last_row ? ST_FIN : ST_FETCH;
                end
                ST_FIN:  state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Memory port and status decode from the state
    always_comb begin
        mem_rd    = (state == ST_FETCH) || (state == ST_RD_A) || (state == ST_RD_B);
        mem_wr    = (state == ST_WR_A) || (state == ST_WR_B);
        mem_wdata = mem_rdata ^ ((state == ST_WR_B) ? part_b : part_a);
        case (state)
            ST_FETCH:        mem_addr = spr_addr;
            ST_RD_A, ST_WR_A: mem_addr = addr_a;
            ST_RD_B, ST_WR_B: mem_addr = addr_b;
            default:         mem_addr = '0;
        endcase
        busy      = (state != ST_IDLE);
        done      = (state == ST_FIN);
        collision = coll_r;
    end

endmodule

// Checker for the blitter's port behaviour, attached by bind below.
// Assumes the bound base address is the one captured for the current draw.
module blit_checker #(
    parameter int ADDR_W   = 16,
    parameter int ROWS_W   = 4,
    parameter int FB_BYTES = 256
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [ROWS_W-1:0] rows,
    input logic              vblank_tick,
    input logic              busy,
    input logic              done,
    input logic              collision,
    input logic              blank_wait_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic [ADDR_W-1:0] base_q
);
    assert_one_access_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

    assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd && !mem_wr));

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);

    assert_zero_rows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && rows == '0) |=> (done && !collision && !mem_rd && !mem_wr));

    assert_coll_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> !collision);

    assert_write_in_fb_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr |-> (mem_addr >= base_q && mem_addr < base_q + ADDR_W'(FB_BYTES)));

    assert_wait_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_wait_req && !vblank_tick) |=> blank_wait_req);
endmodule

bind sprite_xor_blitter blit_checker #(
    .ADDR_W   (ADDR_W),
    .ROWS_W   (ROWS_W),
    .FB_BYTES (FB_BYTES)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .start          (start),
    .rows           (rows),
    .vblank_tick    (vblank_tick),
    .busy           (busy),
    .done           (done),
    .collision      (collision),
    .blank_wait_req (blank_wait_req),
    .mem_addr       (mem_addr),
    .mem_rd         (mem_rd),
    .mem_wr         (mem_wr),
    .base_q         (base_r)
);

// File: tb/sprite_xor_blitter_tb.sv
// Bench for sprite_xor_blitter: byte memory model, reference draw model,
// directed corner cases and seeded random draws.
module sprite_xor_blitter_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MEM_SZ     = 4096;
    localparam int FB_BASE    = 'hF00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  pos_x = '0, pos_y = '0;
    logic [3:0]  rows = '0;
    logic [15:0] src_addr = '0, fb_base = 16'(FB_BASE);
    logic        wait_en = 1'b0, vblank_tick = 1'b0;
    logic        busy, done, collision, blank_wait_req;
    logic [15:0] mem_addr;
    logic        mem_rd, mem_wr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata = '0;

    logic [7:0]  mem     [0:MEM_SZ-1];
    logic [7:0]  ref_mem [0:MEM_SZ-1];

    int checks = 0, failures = 0, both_cycles = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sprite_xor_blitter dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .pos_x(pos_x), .pos_y(pos_y),
        .rows(rows), .src_addr(src_addr), .fb_base(fb_base), .wait_en(wait_en),
        .vblank_tick(vblank_tick), .busy(busy), .done(done), .collision(collision),
        .blank_wait_req(blank_wait_req), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    // Byte memory with one-cycle read latency
    always @(posedge clk) begin
        if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
        if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;
    end

    // Monitor for simultaneous read and write strobes
    always @(negedge clk) if (rst_n && mem_rd && mem_wr) both_cycles++;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Reference draw per the requirements
    task automatic ref_draw(input int x, input int y, input int n, input int i,
                            output bit coll, output int cyc);
        int xs, ys, col, off, a;
        logic [7:0] s, hi, lo;
        logic [15:0] w;
        xs = x % 64; ys = y % 32; col = xs / 8; off = xs % 8;
        coll = 0; cyc = 1;
        for (int r = 0; r < n; r++) begin
            if (ys + r >= 32) break;
            s  = ref_mem[(i + r) % MEM_SZ];
            w  = {s, 8'h00} >> off;
            hi = w[15:8]; lo = w[7:0];
            a  = FB_BASE + 8 * (ys + r) + col;
            if ((ref_mem[a] & hi) != 0) coll = 1;
            ref_mem[a] = ref_mem[a] ^ hi;
            if (off != 0 && col != 7) begin
                if ((ref_mem[a+1] & lo) != 0) coll = 1;
                ref_mem[a+1] = ref_mem[a+1] ^ lo;
                cyc += 5;
            end else begin
                cyc += 3;
            end
        end
    endtask

    // Run one draw and compare timing, flag and framebuffer
    task automatic draw(input int x, input int y, input int n, input int i,
                        input bit wq, input bit poke, input string req);
        bit ecoll; int ecyc, cnt, bad, bad_a;
        ref_draw(x, y, n, i, ecoll, ecyc);
        pos_x = 8'(x); pos_y = 8'(y); rows = 4'(n); src_addr = 16'(i); wait_en = wq;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0; wait_en = 1'b0;
        cnt = 1;
        while (!done && cnt < 400) begin
            if (poke && cnt == 2) begin
                start = 1'b1; rows = 4'd0; pos_x = 8'd3;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            cnt++;
        end
        start = 1'b0;
        chk(cnt == ecyc, {req, " R8 done latency"}, cnt, ecyc);
        chk(collision == ecoll, {req, " R6 collision"}, collision, ecoll);
        bad = 0; bad_a = 0;
        for (int a = FB_BASE; a < FB_BASE + 256; a++)
            if (mem[a] !== ref_mem[a]) begin bad++; bad_a = a; end
        chk(bad == 0, {req, " R3 framebuffer"}, bad == 0 ? 0 : int'(mem[bad_a]),
            int'(ref_mem[bad_a]));
        @(negedge clk);
        chk(!done && !busy, {req, " R8 done one cycle"}, done, 0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int a = 0; a < MEM_SZ; a++) begin
            mem[a] = 8'($urandom);
            ref_mem[a] = mem[a];
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(!busy && !done, "R1 busy/done after reset", {busy, done}, 0);
        chk(!collision && !blank_wait_req, "R1 flags after reset",
            {collision, blank_wait_req}, 0);
        chk(!mem_rd && !mem_wr, "R1 memory idle in reset", {mem_rd, mem_wr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !collision, "R1 idle after release", {busy, done, collision}, 0);

        // Clear framebuffer for directed cases
        for (int a = FB_BASE; a < FB_BASE + 256; a++) begin
            mem[a] = 8'h00; ref_mem[a] = 8'h00;
        end
        for (int r = 0; r < 16; r++) begin
            mem['h300 + r] = 8'hFF ^ 8'(r * 17); ref_mem['h300 + r] = mem['h300 + r];
        end
        mem['h300] = 8'hFF; ref_mem['h300] = 8'hFF;

        draw(0, 0, 5, 'h300, 0, 0, "R3 aligned");
        chk(mem[FB_BASE] == 8'hFF, "R3 first byte lit", mem[FB_BASE], 8'hFF);
        draw(0, 0, 5, 'h300, 0, 0, "R6 redraw erases");
        chk(collision, "R6 collision on redraw", collision, 1);
        draw(3, 4, 4, 'h300, 0, 0, "R4 straddle");
        chk(mem[FB_BASE + 32] == 8'h1F && mem[FB_BASE + 33] == 8'hE0,
            "R4 straddle split", {mem[FB_BASE+32], mem[FB_BASE+33]}, 16'h1FE0);
        draw(61, 10, 3, 'h300, 0, 0, "R4 right clip");
        chk(mem[FB_BASE + 80 + 7] == 8'h07 && mem[FB_BASE + 88] == 8'h00,
            "R4 no horizontal wrap", {mem[FB_BASE+87], mem[FB_BASE+88]}, 16'h0700);
        draw(56, 12, 2, 'h300, 0, 0, "R4 last byte aligned");
        draw(64 + 20, 32 + 14, 6, 'h300, 0, 0, "R2 coordinate wrap");
        chk(mem[FB_BASE + 8*14 + 2] == 8'h0F, "R2 wrapped byte", mem[FB_BASE + 8*14 + 2], 8'h0F);
        draw(9, 29, 8, 'h300, 0, 0, "R5 bottom clip");
        draw(200, 31, 15, 'h300, 0, 0, "R5 last row only");
        draw(0, 0, 5, 'h300, 0, 0, "R6 set before zero");
        draw(5, 5, 0, 'h300, 0, 0, "R7 zero rows");
        chk(!collision, "R7 zero rows clears flag", collision, 0);
        draw(10, 3, 4, 'h300, 0, 1, "R8 start ignored while busy");

        // R10: blank-wait request
        draw(1, 1, 1, 'h300, 1, 0, "R10 wait draw");
        chk(blank_wait_req, "R10 request held", blank_wait_req, 1);
        repeat (3) @(negedge clk);
        chk(blank_wait_req, "R10 request held without tick", blank_wait_req, 1);
        vblank_tick = 1'b1;
        @(negedge clk);
        vblank_tick = 1'b0;
        chk(!blank_wait_req, "R10 request cleared by tick", blank_wait_req, 0);
        draw(1, 1, 1, 'h300, 0, 0, "R10 no wait draw");
        chk(!blank_wait_req, "R10 no request without enable", blank_wait_req, 0);

        // Random draws over a random screen
        for (int a = FB_BASE; a < FB_BASE + 256; a++) begin
            mem[a] = 8'($urandom) & 8'($urandom); ref_mem[a] = mem[a];
        end
        for (int k = 0; k < 60; k++) begin
            draw(int'($urandom % 256), int'($urandom % 256), int'($urandom % 16),
                 'h200 + int'($urandom % 64) * 16, 0, 0, "R3 random");
        end

        chk(both_cycles == 0, "R9 single access per cycle", both_cycles, 0);
        summary();
    end
endmodule